// File: doc/BRIEF.md
# Timer Output Compare Channel with Forced Levels

This block is a single output channel of a timer. Every clock cycle it compares an external free-running count against a compare value. From the result and a 3-bit behaviour selector it maintains a reference waveform bit. The output pin value is that reference, optionally inverted by a polarity bit and gated by an output enable. The counter that supplies the count is not part of this block.

The selector can hold the reference where it is, set it on a match, clear it on a match, or toggle it on a match. Two further codes pin the reference at its active (high) or inactive (low) level. In those pinned codes the comparison keeps running: a match still raises the sticky compare flag and still fires the interrupt and DMA request strobes, but it no longer moves the reference.

The compare value is taken either straight from the written value or from a shadow copy. The shadow copy is refreshed only on an update event, which lets software stage a new value without disturbing the period in progress.

Top module: `oc_channel`

## Requirements
- R1: While `rstN` is low, `ocRef`, `matchFlag`, `irqPulse` and `dmaPulse` are 0 and the shadow compare value is 0.
- R2: A match is `cntVal` equal to the effective compare value in a cycle with `chanSel` = 2'b00. With `ocMode` 3'b000, and also with the unused codes 3'b110 and 3'b111, `ocRef` keeps its value.
- R3: With `ocMode` 3'b001, a match sets `ocRef` to 1 at the next clock edge. With `ocMode` 3'b010, a match clears `ocRef` to 0 at the next clock edge. Without a match, `ocRef` holds.
- R4: With `ocMode` 3'b011, each match cycle inverts `ocRef` at the next clock edge.
- R5: With `ocMode` 3'b101, `ocRef` becomes 1 at the next edge. With `ocMode` 3'b100, `ocRef` becomes 0 at the next edge. In both codes this happens whether or not a match occurs.
- R6: `ocOut` equals `ocRef` XOR `polarity` when `outEn` is 1 and `chanSel` is 2'b00. Otherwise `ocOut` is 0.
- R7: A match sets `matchFlag` at the next edge in every mode, the forced ones included. The flag stays set until `flagClr` is high at an edge with no match. If a match and `flagClr` arrive together, the flag is set.
- R8: A match with `intEn` = 1 gives a one-cycle `irqPulse` after the next edge. A match with `dmaEn` = 1 gives a one-cycle `dmaPulse` after the next edge. This also holds in the forced modes.
- R9: With `chanSel` other than 2'b00, `ocRef` holds, the flag is not set, no request pulses occur, and `ocOut` is 0.
- R10: With `preloadEn` = 0, the compare value is `preloadVal` directly. With `preloadEn` = 1, the compare value is a shadow register that copies `preloadVal` at an edge where `updateEvt` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntVal | input | CNT_W | Current counter value |
| preloadVal | input | CNT_W | Written compare value |
| preloadEn | input | 1 | Use shadow compare value |
| updateEvt | input | 1 | Update event, loads the shadow |
| chanSel | input | 2 | Channel direction select, 00 = output |
| ocMode | input | 3 | Reference behaviour selector |
| polarity | input | 1 | 1 inverts the pin value |
| outEn | input | 1 | Output enable |
| intEn | input | 1 | Interrupt request enable |
| dmaEn | input | 1 | DMA request enable |
| flagClr | input | 1 | Clear the compare flag |
| ocRef | output | 1 | Reference waveform |
| ocOut | output | 1 | Output pin value |
| matchFlag | output | 1 | Sticky compare flag |
| irqPulse | output | 1 | Interrupt request strobe |
| dmaPulse | output | 1 | DMA request strobe |

## Verification
The reference is driven through a sequence that alternates match and non-match counts under every mode code. This separates edge-triggered set, clear and toggle from plain holding, and shows that a repeated match toggles twice. Forced codes are applied both with and without a match. The result shows that the reference ignores the comparison while the flag and request strobes still follow it. Polarity is flipped within the sequence to tell inversion apart from the reference itself. Staged compare values are tried before and after an update event, with a conflicting direct value present, to show which copy the comparator uses.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    MODE_FROZEN   = 3'b000,
    MODE_SET      = 3'b001,
    MODE_CLEAR    = 3'b010,
    MODE_TOGGLE   = 3'b011,
    MODE_FORCE_LO = 3'b100,
    MODE_FORCE_HI = 3'b101
  } ocMode_e;

  typedef struct packed {
    logic setRef;
    logic clrRef;
    logic togRef;
  } refCtrl_t;
endpackage

// File: rtl/oc_datapath.sv
module oc_datapath
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntVal,
  input  logic [CNT_W-1:0] preloadVal,
  input  logic             preloadEn,
  input  logic             updateEvt,
  input  logic             isOutput,
  input  logic             polarity,
  input  logic             outEn,
  input  refCtrl_t         refCtrl,
  output logic [CNT_W-1:0] cmpEff,
  output logic             match,
  output logic             ocRef,
  output logic             ocOut
);
  logic [CNT_W-1:0] shadowVal;

  always_ff @(posedge clk) begin
    if (!rstN) shadowVal <= '0;
    else if (updateEvt) shadowVal <= preloadVal;
  end

  assign cmpEff = preloadEn ? shadowVal : preloadVal;
  assign match  = isOutput && (cntVal == cmpEff);

  always_ff @(posedge clk) begin
    if (!rstN) ocRef <= 1'b0;
    else if (refCtrl.setRef) ocRef <= 1'b1;
    else if (refCtrl.clrRef) ocRef <= 1'b0;
    else if (refCtrl.togRef) ocRef <= ~ocRef;
  end

  assign ocOut = (outEn && isOutput) ? (ocRef ^ polarity) : 1'b0;
endmodule

// File: rtl/oc_control.sv
module oc_control
  import oc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     isOutput,
  input  logic [2:0] ocMode,
  input  logic     match,
  input  logic     intEn,
  input  logic     dmaEn,
  input  logic     flagClr,
  output refCtrl_t refCtrl,
  output logic     matchFlag,
  output logic     irqPulse,
  output logic     dmaPulse
);
  always_comb begin
    refCtrl = '0;
    if (isOutput) begin
      unique case (ocMode)
        MODE_SET:      refCtrl.setRef = match;
        MODE_CLEAR:    refCtrl.clrRef = match;
        MODE_TOGGLE:   refCtrl.togRef = match;
        MODE_FORCE_HI: refCtrl.setRef = 1'b1;
        MODE_FORCE_LO: refCtrl.clrRef = 1'b1;
        default:       refCtrl = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchFlag <= 1'b0;
      irqPulse  <= 1'b0;
      dmaPulse  <= 1'b0;
    end else begin
      if (match) matchFlag <= 1'b1;
      else if (flagClr) matchFlag <= 1'b0;
      irqPulse <= match && intEn;
      dmaPulse <= match && dmaEn;
    end
  end
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntVal,
  input  logic [CNT_W-1:0] preloadVal,
  input  logic             preloadEn,
  input  logic             updateEvt,
  input  logic [1:0]       chanSel,
  input  logic [2:0]       ocMode,
  input  logic             polarity,
  input  logic             outEn,
  input  logic             intEn,
  input  logic             dmaEn,
  input  logic             flagClr,
  output logic             ocRef,
  output logic             ocOut,
  output logic             matchFlag,
  output logic             irqPulse,
  output logic             dmaPulse
);
  localparam logic [1:0] SEL_OUTPUT = 2'b00;

  logic             isOutput;
  logic             match;
  logic [CNT_W-1:0] cmpEff;
  refCtrl_t         refCtrl;

  assign isOutput = (chanSel == SEL_OUTPUT);

  oc_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .preloadVal(preloadVal),
    .preloadEn(preloadEn), .updateEvt(updateEvt), .isOutput(isOutput),
    .polarity(polarity), .outEn(outEn), .refCtrl(refCtrl),
    .cmpEff(cmpEff), .match(match), .ocRef(ocRef), .ocOut(ocOut)
  );

  oc_control ctl_i (
    .clk(clk), .rstN(rstN), .isOutput(isOutput), .ocMode(ocMode),
    .match(match), .intEn(intEn), .dmaEn(dmaEn), .flagClr(flagClr),
    .refCtrl(refCtrl), .matchFlag(matchFlag), .irqPulse(irqPulse),
    .dmaPulse(dmaPulse)
  );
endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] cmpEff,
  input logic [1:0]       chanSel,
  input logic [2:0]       ocMode,
  input logic             outEn,
  input logic             intEn,
  input logic             dmaEn,
  input logic             ocRef,
  input logic             ocOut,
  input logic             matchFlag,
  input logic             irqPulse,
  input logic             dmaPulse
);
  logic hit;
  assign hit = (chanSel == 2'b00) && (cntVal == cmpEff);

  // R5
  force_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanSel == 2'b00 && ocMode == 3'b101) |=> ocRef);
  // R5
  force_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanSel == 2'b00 && ocMode == 3'b100) |=> !ocRef);
  // R2
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ocMode == 3'b000) |=> $stable(ocRef));
  // R9
  inactive_chan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanSel != 2'b00) |=> ($stable(ocRef) && !irqPulse && !dmaPulse));
  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> matchFlag);
  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPulse) |-> $past(hit && intEn));
  // R8
  dma_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaPulse) |-> $past(hit && dmaEn));
  // R6
  out_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!outEn || chanSel != 2'b00) |-> !ocOut);
endmodule

bind oc_channel oc_channel_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .cntVal(cntVal), .cmpEff(cmpEff),
  .chanSel(chanSel), .ocMode(ocMode), .outEn(outEn), .intEn(intEn),
  .dmaEn(dmaEn), .ocRef(ocRef), .ocOut(ocOut), .matchFlag(matchFlag),
  .irqPulse(irqPulse), .dmaPulse(dmaPulse)
);

// File: tb/oc_channel_tb.sv
module oc_channel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int NVEC = 12;

  // {mode[2:0], pol, cnt[7:0], expRef, expOut, expIrq}
  localparam logic [14:0] VEC [NVEC] = '{
    {3'b001, 1'b0, 8'd3, 1'b0, 1'b0, 1'b0},
    {3'b001, 1'b0, 8'd5, 1'b1, 1'b1, 1'b1},
    {3'b000, 1'b0, 8'd5, 1'b1, 1'b1, 1'b1},
    {3'b010, 1'b1, 8'd4, 1'b1, 1'b0, 1'b0},
    {3'b010, 1'b1, 8'd5, 1'b0, 1'b1, 1'b1},
    {3'b011, 1'b0, 8'd5, 1'b1, 1'b1, 1'b1},
    {3'b011, 1'b0, 8'd5, 1'b0, 1'b0, 1'b1},
    {3'b011, 1'b0, 8'd2, 1'b0, 1'b0, 1'b0},
    {3'b101, 1'b0, 8'd2, 1'b1, 1'b1, 1'b0},
    {3'b101, 1'b0, 8'd5, 1'b1, 1'b1, 1'b1},
    {3'b100, 1'b1, 8'd5, 1'b0, 1'b1, 1'b1},
    {3'b100, 1'b0, 8'd7, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CNT_W-1:0] cntVal = '0, preloadVal = 16'd5;
  logic preloadEn = 1'b0, updateEvt = 1'b0;
  logic [1:0] chanSel = 2'b00;
  logic [2:0] ocMode = 3'b000;
  logic polarity = 1'b0, outEn = 1'b1, intEn = 1'b1, dmaEn = 1'b0, flagClr = 1'b0;
  logic ocRef, ocOut, matchFlag, irqPulse, dmaPulse;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oc_channel #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .preloadVal(preloadVal),
    .preloadEn(preloadEn), .updateEvt(updateEvt), .chanSel(chanSel),
    .ocMode(ocMode), .polarity(polarity), .outEn(outEn), .intEn(intEn),
    .dmaEn(dmaEn), .flagClr(flagClr), .ocRef(ocRef), .ocOut(ocOut),
    .matchFlag(matchFlag), .irqPulse(irqPulse), .dmaPulse(dmaPulse)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) step();
    chk("R1 ocRef", ocRef, 1'b0);
    chk("R1 matchFlag", matchFlag, 1'b0);
    chk("R1 irqPulse", irqPulse, 1'b0);
    chk("R1 dmaPulse", dmaPulse, 1'b0);
    rstN = 1'b1;

    // Table walk: R2 R3 R4 R5 R6 R8, compare value 5
    for (int i = 0; i < NVEC; i++) begin
      ocMode   = VEC[i][14:12];
      polarity = VEC[i][11];
      cntVal   = {8'd0, VEC[i][10:3]};
      step();
      chk($sformatf("R3/R4/R5 ref vec%0d", i), ocRef, VEC[i][2]);
      chk($sformatf("R6 out vec%0d", i), ocOut, VEC[i][1]);
      chk($sformatf("R8 irq vec%0d", i), irqPulse, VEC[i][0]);
    end

    // R2 unused code holds reference
    ocMode = 3'b101; cntVal = 16'd1; step();
    ocMode = 3'b110; cntVal = 16'd5; step();
    chk("R2 code110 hold", ocRef, 1'b1);

    // R7 sticky flag, clear, set wins, forced mode still sets flag
    cntVal = 16'd1; step();
    chk("R8 irq single cycle", irqPulse, 1'b0);
    chk("R7 flag sticky", matchFlag, 1'b1);
    flagClr = 1'b1; step();
    chk("R7 flag cleared", matchFlag, 1'b0);
    ocMode = 3'b100; cntVal = 16'd5; step();
    chk("R7 set wins over clear in forced mode", matchFlag, 1'b1);
    chk("R5 forced low ignores match", ocRef, 1'b0);
    flagClr = 1'b0;

    // R8 enables
    intEn = 1'b0; dmaEn = 1'b1; ocMode = 3'b000; cntVal = 16'd5; step();
    chk("R8 irq gated off", irqPulse, 1'b0);
    chk("R8 dma pulse", dmaPulse, 1'b1);
    cntVal = 16'd0; step();
    chk("R8 dma single cycle", dmaPulse, 1'b0);

    // R9 inactive channel
    flagClr = 1'b1; step(); flagClr = 1'b0;
    chanSel = 2'b01; ocMode = 3'b101; cntVal = 16'd5; polarity = 1'b1; step();
    chk("R9 ref held", ocRef, 1'b0);
    chk("R9 no flag", matchFlag, 1'b0);
    chk("R9 no dma", dmaPulse, 1'b0);
    chk("R9 out low", ocOut, 1'b0);
    chanSel = 2'b00; ocMode = 3'b100; cntVal = 16'd0; step();

    // R6 output enable
    outEn = 1'b0; step();
    chk("R6 outEn low", ocOut, 1'b0);
    outEn = 1'b1; polarity = 1'b0;

    // R10 shadow compare
    preloadEn = 1'b1; preloadVal = 16'd9; ocMode = 3'b001; cntVal = 16'd9; step();
    chk("R10 shadow not loaded", ocRef, 1'b0);
    updateEvt = 1'b1; cntVal = 16'd3; step();
    updateEvt = 1'b0; preloadVal = 16'd2; cntVal = 16'd9; step();
    chk("R10 shadow used", ocRef, 1'b1);
    preloadEn = 1'b0; ocMode = 3'b010; cntVal = 16'd2; step();
    chk("R10 direct value", ocRef, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule